// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the two timing strobes a UART needs: an oversample enable at sixteen times the bit rate, and a bit-rate enable. Two stages divide the system clock. The first is a fractional pre-divider: a 9-bit phase accumulator advances by a programmed step of N/512 on every clock. The second is an integer counter that reloads on a programmed value. A third small counter turns every sixteenth oversample strobe into one bit strobe. The resulting oversample rate is f_clk × (N/512) / (LOAD + 1).

Software programs the block in a fixed order. It stops the generator, chooses whether the fractional stage is used, writes the step value, writes the reload value and then starts the generator again. The step and reload registers are frozen while the generator runs. Stopping the generator silences both strobes and returns every stage to its starting phase, so the next start behaves the same as the first one.

Top module: `frac_baud_gen`

## Requirements
- R1: While the run bit is clear, after reset and from the second clock after run is cleared, both os_tick and bit_tick stay low. Neither strobe is ever high unless run was set in the previous cycle.
- R2: With the fractional enable clear (bypass), os_tick pulses once every LOAD+1 clocks, and the step value has no effect on the rate.
- R3: With the fractional enable set and a step value N in 1..511, the counter advances on N of every 512 clocks. When 512×(LOAD+1)/N is an integer, os_tick repeats every 512×(LOAD+1)/N clocks.
- R4: With the fractional enable set, a step value of 0 acts as 512: the counter advances on every clock, the same as bypass.
- R5: bit_tick is a one-cycle pulse that comes one clock after every 16th os_tick, so it repeats every 16 os_tick periods.
- R6: In bypass, or with step 0, the first os_tick goes high after the (LOAD+2)-th rising edge counted from the edge that samples the run write. The first bit_tick goes high one edge after the 16th os_tick.
- R7: Writes to the step or reload register while run is set are dropped, and the previous values stay in use.
- R8: Clearing run resets the accumulator and both counters. A later start repeats the first-tick timing of R6.
- R9: Writes to the step and reload registers made while run is clear take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit value written with ctl_we |
| ctl_frac_en | input | 1 | Fractional-stage enable written with ctl_we |
| fdv_we | input | 1 | Step register write strobe (ignored while running) |
| fdv_wdata | input | FRAC_W | Fractional step N; 0 means 512 |
| rld_we | input | 1 | Reload register write strobe (ignored while running) |
| rld_wdata | input | RLD_W | Reload value LOAD |
| os_tick | output | 1 | Oversample enable, one cycle per pulse |
| bit_tick | output | 1 | Bit-rate enable, one cycle per pulse |

## Verification
A write is captured on the edge that samples its strobe. The fractional stage, the reload counter and the bit divider each add one register, so in bypass the first os_tick is visible after edge LOAD+2 and bit_tick follows one edge after the 16th os_tick. The bench drives inputs and reads outputs one time unit after each rising edge. It numbers the edges from the one that takes the run write, and it compares those edge numbers, and the spacing between successive strobes, with values worked out from the formulas. The stop check reads the outputs after the second edge following the clear, which is the first edge at which R1 holds.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Control word captured on a control write.
  typedef struct packed {
    logic run;
    logic frac_en;
  } fbg_ctl_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int RLD_W  = 16,
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  fbg_ctl_t          ctl_wdata,
  input  logic              fdv_we,
  input  logic [FRAC_W-1:0] fdv_wdata,
  input  logic              rld_we,
  input  logic [RLD_W-1:0]  rld_wdata,
  output fbg_ctl_t          ctl_q,
  output logic [FRAC_W-1:0] fdv_q,
  output logic [RLD_W-1:0]  rld_q
);
  logic unlocked;
  assign unlocked = ~ctl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      fdv_q <= '0;
      rld_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (fdv_we && unlocked) fdv_q <= fdv_wdata;
      if (rld_we && unlocked) rld_q <= rld_wdata;
    end
  end
endmodule

// File: rtl/fbg_frac.sv
module fbg_frac #(
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              frac_en,
  input  logic [FRAC_W-1:0] fdv,
  output logic              step
);
  localparam int unsigned MODULUS = 1 << FRAC_W;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   incr;
  logic [FRAC_W:0]   sum;

  // A zero step stands for the full modulus (ratio 1:1).
  assign incr = (fdv == '0) ? (FRAC_W+1)'(MODULUS) : {1'b0, fdv};
  assign sum  = {1'b0, acc_q} + incr;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc_q <= '0;
      step  <= 1'b0;
    end else if (!frac_en) begin
      acc_q <= '0;
      step  <= 1'b1;
    end else begin
      step  <= sum[FRAC_W];
      acc_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fbg_reload.sv
module fbg_reload #(
  parameter int RLD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic [RLD_W-1:0] load,
  output logic             tick
);
  logic [RLD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      cnt_q <= load;
      tick  <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_q <= load;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/fbg_bitdiv.sv
module fbg_bitdiv #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic os_in,
  output logic bit_out
);
  generate
    if (OVERSAMPLE <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst || !run) bit_out <= 1'b0;
        else             bit_out <= os_in;
      end
    end else begin : g_div
      localparam int CW = $clog2(OVERSAMPLE);
      localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q   <= '0;
          bit_out <= 1'b0;
        end else if (os_in) begin
          bit_out <= (cnt_q == LAST);
          cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end else begin
          bit_out <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int RLD_W      = 16,
  parameter int FRAC_W     = 9,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_run,
  input  logic              ctl_frac_en,
  input  logic              fdv_we,
  input  logic [FRAC_W-1:0] fdv_wdata,
  input  logic              rld_we,
  input  logic [RLD_W-1:0]  rld_wdata,
  output logic              os_tick,
  output logic              bit_tick
);
  fbg_ctl_t          ctl_wdata;
  fbg_ctl_t          ctl_q;
  logic [FRAC_W-1:0] fdv_q;
  logic [RLD_W-1:0]  rld_q;
  logic              run_q;
  logic              step;

  assign ctl_wdata.run     = ctl_run;
  assign ctl_wdata.frac_en = ctl_frac_en;
  assign run_q             = ctl_q.run;

  fbg_regs #(.RLD_W(RLD_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .fdv_we(fdv_we), .fdv_wdata(fdv_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ctl_q(ctl_q), .fdv_q(fdv_q), .rld_q(rld_q)
  );

  fbg_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .run(run_q), .frac_en(ctl_q.frac_en),
    .fdv(fdv_q), .step(step)
  );

  fbg_reload #(.RLD_W(RLD_W)) u_reload (
    .clk(clk), .rst(rst), .run(run_q), .step(step),
    .load(rld_q), .tick(os_tick)
  );

  fbg_bitdiv #(.OVERSAMPLE(OVERSAMPLE)) u_bitdiv (
    .clk(clk), .rst(rst), .run(run_q), .os_in(os_tick), .bit_out(bit_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int RLD_W  = 16,
  parameter int FRAC_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              run_q,
  input logic [FRAC_W-1:0] fdv_q,
  input logic [RLD_W-1:0]  rld_q,
  input logic              os_tick,
  input logic              bit_tick
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !$past(run_q)) |-> (!os_tick && !bit_tick)); // R1

  AST_OS_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    os_tick |-> $past(run_q)); // R1

  AST_BIT_AFTER_OS: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> $past(os_tick)); // R5

  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R5

  AST_LOCK_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(run_q) |-> $stable(fdv_q)); // R7

  AST_LOCK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $past(run_q) |-> $stable(rld_q)); // R7
endmodule

bind frac_baud_gen fbg_checker #(.RLD_W(RLD_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .fdv_q(fdv_q), .rld_q(rld_q),
  .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  localparam int RLD_W  = 16;
  localparam int FRAC_W = 9;
  localparam int NVEC   = 7;

  // {frac_en[41], step[40:32], load[31:16], expected os period[15:0]}
  localparam logic [41:0] VECS [NVEC] = '{
    {1'b0, 9'd0,   16'd3, 16'd4},  // R2 bypass
    {1'b0, 9'd128, 16'd5, 16'd6},  // R2 step ignored in bypass
    {1'b1, 9'd256, 16'd2, 16'd6},  // R3 half rate
    {1'b1, 9'd128, 16'd1, 16'd8},  // R3 quarter rate
    {1'b1, 9'd384, 16'd2, 16'd4},  // R3 three quarters
    {1'b1, 9'd320, 16'd4, 16'd8},  // R3 five eighths
    {1'b1, 9'd0,   16'd6, 16'd7}   // R4 zero step means 512
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0, ctl_run = 1'b0, ctl_frac_en = 1'b0;
  logic fdv_we = 1'b0, rld_we = 1'b0;
  logic [FRAC_W-1:0] fdv_wdata = '0;
  logic [RLD_W-1:0]  rld_wdata = '0;
  logic os_tick, bit_tick;

  int tests = 0, fails = 0;
  int os_t [3];
  int bit_t [2];
  int os_n, bit_n, os_hi;

  always #2 clk = ~clk;

  frac_baud_gen #(.RLD_W(RLD_W), .FRAC_W(FRAC_W), .OVERSAMPLE(16)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_frac_en(ctl_frac_en), .fdv_we(fdv_we), .fdv_wdata(fdv_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic run, input logic fe);
    ctl_we = 1'b1; ctl_run = run; ctl_frac_en = fe;
    edge1();
    ctl_we = 1'b0;
  endtask

  task automatic wr_fdv(input int v);
    fdv_we = 1'b1; fdv_wdata = FRAC_W'(v);
    edge1();
    fdv_we = 1'b0;
  endtask

  task automatic wr_rld(input int v);
    rld_we = 1'b1; rld_wdata = RLD_W'(v);
    edge1();
    rld_we = 1'b0;
  endtask

  // Stop, program, start; returns just after the edge taking the run write.
  task automatic program_start(input logic fe, input int fdv, input int rld);
    wr_ctl(1'b0, fe);
    wr_fdv(fdv);
    wr_rld(rld);
    wr_ctl(1'b1, fe);
  endtask

  // Edge numbers (from the run-write edge) of the first strobes.
  task automatic measure(input int limit);
    os_n = 0; bit_n = 0; os_hi = 0;
    for (int n = 1; n <= limit; n++) begin
      edge1();
      if (os_tick) begin
        os_hi++;
        if (os_n < 3) begin os_t[os_n] = n; os_n++; end
      end
      if (bit_tick && bit_n < 2) begin bit_t[bit_n] = n; bit_n++; end
    end
  endtask

  task automatic count_quiet(input int cycles, output int hits);
    hits = 0;
    for (int n = 0; n < cycles; n++) begin
      edge1();
      if (os_tick || bit_tick) hits++;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog (R1..): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int hits;
    int per, rld, fdv;
    logic fe;
    repeat (3) edge1();
    rst = 1'b0;
    edge1();
    // R1: reset state and idle
    chk("R1 os_tick after reset", int'(os_tick), 0);
    chk("R1 bit_tick after reset", int'(bit_tick), 0);
    count_quiet(30, hits);
    chk("R1 strobes while idle", hits, 0);

    // Vector table: R2, R3, R4, R5, R6
    for (int i = 0; i < NVEC; i++) begin
      fe  = VECS[i][41];
      fdv = int'(VECS[i][40:32]);
      rld = int'(VECS[i][31:16]);
      per = int'(VECS[i][15:0]);
      program_start(fe, fdv, rld);
      measure(40 * per + 20);
      chk($sformatf("R2/R3/R4 vec%0d os count", i), os_n, 3);
      chk($sformatf("R2/R3/R4 vec%0d os period a", i), os_t[1] - os_t[0], per);
      chk($sformatf("R2/R3/R4 vec%0d os period b", i), os_t[2] - os_t[1], per);
      chk($sformatf("R5 vec%0d bit count", i), bit_n, 2);
      chk($sformatf("R5 vec%0d bit period", i), bit_t[1] - bit_t[0], 16 * per);
      chk($sformatf("R5 vec%0d bit after 16th os", i), bit_t[0], os_t[0] + 15 * per + 1);
      if (!fe || fdv == 0)
        chk($sformatf("R6 vec%0d first os latency", i), os_t[0], rld + 2);
    end

    // R6: LOAD = 0 bypass, os every clock, first bit after 16th os
    program_start(1'b0, 0, 0);
    measure(30);
    chk("R6 first os edge", os_t[0], 2);
    chk("R6 os every clock", os_t[1] - os_t[0], 1);
    chk("R6 first bit edge", bit_t[0], 18);
    chk("R5 os high cycles in window", os_hi, 29);

    // R7: writes while running are dropped
    program_start(1'b0, 0, 3);
    wr_rld(9);
    wr_fdv(64);
    measure(150);
    chk("R7 os period kept", os_t[2] - os_t[1], 4);
    chk("R7 bit period kept", bit_t[1] - bit_t[0], 64);

    // R8: stop silences strobes from the second edge
    wr_ctl(1'b0, 1'b0);
    edge1();
    chk("R8 os_tick after stop", int'(os_tick), 0);
    chk("R8 bit_tick after stop", int'(bit_tick), 0);
    count_quiet(40, hits);
    chk("R1 quiet after stop", hits, 0);

    // R7 again at the ports: rld still 3 after restart without rewrite
    wr_ctl(1'b1, 1'b0);
    measure(30);
    chk("R7 load unchanged after restart", os_t[1] - os_t[0], 4);
    chk("R8 restart first os latency", os_t[0], 5);

    // R9: writes while stopped take effect
    wr_ctl(1'b0, 1'b0);
    wr_rld(9);
    wr_ctl(1'b1, 1'b0);
    measure(60);
    chk("R9 new load first os", os_t[0], 11);
    chk("R9 new load period", os_t[1] - os_t[0], 10);

    wr_ctl(1'b0, 1'b0);
    edge1();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule